// File: doc/BRIEF.md
# Event-to-Priority Interrupt Selector

This block sits between a wide bank of event lines and the twelve maskable interrupt inputs of a processor core. Each of the twelve outputs has its own select field. The field names one event line, and the output follows that line's level. Output i drives core priority i + 4, so the twelve outputs cover priorities 4 to 15. Event lines 0 to 3 carry the group-combined interrupts and can be selected like any other line.

Software sets the routing through a word-wide register port. Each mux word holds four 8-bit select fields. The region starts with one word that holds no fields. The three words after it hold the twelve fields, and the words after those are empty. A select value that names no event line parks its output low. After reset every field holds such a value, so every output starts deasserted. Each output passes through one register. A new select value or a new event level therefore reaches the output one clock after it is presented.

Top module: `evt_prio_router`

## Requirements
- R1: Output i (priority i + 4) equals, one clock later, the level of event line `evt_in[s]`, where s is the select field of output i and s is below 128.
- R2: The select field of output i sits in register word 1 + i/4, at bits (i mod 4)*8 + 7 down to (i mod 4)*8.
- R3: Every select value from 0 to 127 is legal, including 0 to 3 (the group-combined lines).
- R4: An output whose select value is 128 to 255 is driven low whatever the event levels are.
- R5: Writes to word 0 and to words 4 to 15 change no select field and no output. Reads of those words return zero.
- R6: After reset every select field reads 8'hFF, so words 1 to 3 read 32'hFFFFFFFF and all twelve outputs are low.
- R7: A write to word 1, 2 or 3 replaces that word's four fields. A read returns them unchanged, so software can change one byte by reading, editing and writing back while the other three fields keep their values.
- R8: A select write presented at clock edge k changes the output at edge k+1. An event level change is seen on the output one edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 128 | Event line levels |
| prio_irq | output | 12 | Interrupt lines; bit i drives core priority i + 4 |

## Verification
Read data is combinational, so the bench checks each readback just after it sets the address, inside the same cycle. Outputs are due one clock edge after their select field and event inputs are sampled. A select written at edge k therefore shows up at edge k+1. The bench's reference model updates its expected outputs on each rising edge from the select values held before that edge, then applies any write. All comparisons happen on the falling edge, where both sides are settled. The latency checks look on the falling edge between the write edge and the next one (old value expected) and on the falling edge after that (new value expected).

// File: rtl/epr_pkg.sv
package epr_pkg;
   // width of one source-select field
   localparam int FIELD_W = 8;
   // value loaded into every field at reset; must name no event line
   localparam logic [FIELD_W-1:0] SEL_PARKED = '1;
endpackage

// File: rtl/epr_sel_bank.sv
module epr_sel_bank
   import epr_pkg::*;
#(
   parameter int NUM_OUTS   = 12,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int FIRST_WORD = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_we,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [DATA_W-1:0]            reg_rdata,
   output logic [NUM_OUTS*FIELD_W-1:0]  sel_flat
);
   localparam int FPW = DATA_W / FIELD_W;

   function automatic logic [ADDR_W-1:0] word_of(input int idx);
      return ADDR_W'(FIRST_WORD + idx / FPW);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_OUTS; i++)
            sel_flat[i*FIELD_W +: FIELD_W] <= SEL_PARKED;
      end else if (reg_we) begin
         for (int i = 0; i < NUM_OUTS; i++)
            if (reg_addr == word_of(i))
               sel_flat[i*FIELD_W +: FIELD_W] <= reg_wdata[(i % FPW)*FIELD_W +: FIELD_W];
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_OUTS; i++)
         if (reg_addr == word_of(i))
            reg_rdata[(i % FPW)*FIELD_W +: FIELD_W] = sel_flat[i*FIELD_W +: FIELD_W];
   end
endmodule

// File: rtl/epr_lane.sv
module epr_lane
   import epr_pkg::*;
#(
   parameter int NUM_EVENTS = 128
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_EVENTS-1:0]  evt_in,
   input  logic [FIELD_W-1:0]     sel,
   output logic                   q
);
   localparam int IDX_W = $clog2(NUM_EVENTS);

   logic             hit;
   logic [IDX_W-1:0] idx;

   assign idx = sel[IDX_W-1:0];

   generate
      if ((1 << IDX_W) == NUM_EVENTS) begin : g_pow2
         assign hit = ~|sel[FIELD_W-1:IDX_W];
      end else begin : g_cmp
         assign hit = (sel < FIELD_W'(NUM_EVENTS));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= hit & evt_in[idx];
   end
endmodule

// File: rtl/evt_prio_router.sv
module evt_prio_router
   import epr_pkg::*;
#(
   parameter int NUM_EVENTS = 128,
   parameter int NUM_OUTS   = 12,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int FIRST_WORD = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [DATA_W-1:0]      reg_rdata,
   input  logic [NUM_EVENTS-1:0]  evt_in,
   output logic [NUM_OUTS-1:0]    prio_irq
);
   localparam int FPW        = DATA_W / FIELD_W;
   localparam int USED_WORDS = (NUM_OUTS + FPW - 1) / FPW;

   generate
      if (DATA_W % FIELD_W != 0) begin : g_bad_w
         $error("DATA_W must hold a whole number of select fields");
      end
      if (NUM_EVENTS >= (1 << FIELD_W) || NUM_EVENTS < 2) begin : g_bad_ev
         $error("NUM_EVENTS must leave a parked select code");
      end
      if (FIRST_WORD + USED_WORDS > (1 << ADDR_W)) begin : g_bad_a
         $error("register words do not fit in the address space");
      end
   endgenerate

   logic [NUM_OUTS*FIELD_W-1:0] sel_flat;

   epr_sel_bank #(
      .NUM_OUTS(NUM_OUTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIRST_WORD(FIRST_WORD)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel_flat(sel_flat)
   );

   generate
      for (genvar i = 0; i < NUM_OUTS; i++) begin : g_lane
         epr_lane #(.NUM_EVENTS(NUM_EVENTS)) u_lane (
            .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
            .sel(sel_flat[i*FIELD_W +: FIELD_W]), .q(prio_irq[i])
         );
      end
   endgenerate
endmodule

// File: rtl/epr_router_chk.sv
module epr_router_chk
   import epr_pkg::*;
#(
   parameter int NUM_EVENTS = 128,
   parameter int NUM_OUTS   = 12,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int FIRST_WORD = 1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         reg_we,
   input logic [ADDR_W-1:0]            reg_addr,
   input logic [DATA_W-1:0]            reg_rdata,
   input logic [NUM_EVENTS-1:0]        evt_in,
   input logic [NUM_OUTS-1:0]          prio_irq,
   input logic [NUM_OUTS*FIELD_W-1:0]  sel_flat
);
   localparam int FPW        = DATA_W / FIELD_W;
   localparam int USED_WORDS = (NUM_OUTS + FPW - 1) / FPW;
   localparam int IDX_W      = $clog2(NUM_EVENTS);
   localparam logic [ADDR_W-1:0] LO_W = ADDR_W'(FIRST_WORD);
   localparam logic [ADDR_W-1:0] HI_W = ADDR_W'(FIRST_WORD + USED_WORDS - 1);

   // R5: empty words read back zero
   p_empty_word_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr < LO_W || reg_addr > HI_W) |-> reg_rdata == '0);

   // R8: no write and steady events keep outputs steady
   p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!reg_we) && $stable(evt_in)) |=> $stable(prio_irq));

   generate
      for (genvar i = 0; i < NUM_OUTS; i++) begin : g_lane_chk
         // R4: parked select keeps the output low
         p_parked_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[i*FIELD_W +: FIELD_W] >= FIELD_W'(NUM_EVENTS)) |=> !prio_irq[i]);
         // R1: live select follows the chosen event one clock later
         p_follow_evt_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[i*FIELD_W +: FIELD_W] < FIELD_W'(NUM_EVENTS)) |=>
               prio_irq[i] == $past(evt_in[sel_flat[i*FIELD_W +: IDX_W]]));
      end
   endgenerate
endmodule

bind evt_prio_router epr_router_chk #(
   .NUM_EVENTS(NUM_EVENTS), .NUM_OUTS(NUM_OUTS), .DATA_W(DATA_W),
   .ADDR_W(ADDR_W), .FIRST_WORD(FIRST_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .evt_in(evt_in), .prio_irq(prio_irq), .sel_flat(sel_flat)
);

// File: tb/sim_evt_prio_router.sv
`timescale 1ns/1ps
module sim_evt_prio_router;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [127:0] evt_in = '0;
   logic [11:0]  prio_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int msel [12];
   logic [11:0] mexp = '0;

   always #10 clk = ~clk;

   evt_prio_router u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .prio_irq(prio_irq)
   );

   // behavioural reference: outputs from pre-edge selects, then apply write
   always @(posedge clk) begin
      if (!rst_n) begin
         mexp = '0;
         for (int i = 0; i < 12; i++) msel[i] = 255;
      end else begin
         for (int i = 0; i < 12; i++)
            mexp[i] = (msel[i] < 128) ? evt_in[msel[i]] : 1'b0;
         if (reg_we && reg_addr >= 1 && reg_addr <= 3)
            for (int s = 0; s < 4; s++)
               msel[(reg_addr - 1) * 4 + s] = int'(reg_wdata[s*8 +: 8]);
      end
   end

   function automatic logic [31:0] model_word(input int a);
      logic [31:0] w = '0;
      if (a >= 1 && a <= 3)
         for (int s = 0; s < 4; s++) w[s*8 +: 8] = 8'(msel[(a - 1) * 4 + s]);
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // every-cycle comparison against the model (R1, R3, R4, R8)
   always @(negedge clk) if (!done) check("R1 per-cycle", 32'(prio_irq), 32'(mexp));

   task automatic wr(input int a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input string req, input int a, input logic [31:0] exp);
      reg_addr = 4'(a);
      #1;
      check(req, reg_rdata, exp);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6: reset state
      check("R6 outputs low", 32'(prio_irq), 32'h0);
      for (int a = 1; a <= 3; a++) rd("R6 field reset", a, 32'hFFFF_FFFF);
      rd("R5 word0 zero", 0, 32'h0);

      // R2/R3/R4: load a mix of live, group and parked selects
      wr(1, {8'd64, 8'd5, 8'd127, 8'd0});
      wr(2, {8'd100, 8'd128, 8'd9, 8'd200});
      wr(3, {8'd126, 8'd2, 8'd1, 8'd3});
      rd("R7 word1 readback", 1, 32'h4005_7F00);
      rd("R7 word2 readback", 2, 32'h6480_09C8);
      rd("R2 word3 layout", 3, 32'h7E02_0103);

      evt_in = '0; evt_in[127] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R2 out1 from event127", 32'(prio_irq), 32'h002);
      evt_in = '0; evt_in[3] = 1'b1;
      @(negedge clk);
      check("R3 group line 3 to out8", 32'(prio_irq), 32'h100);
      evt_in = '1;
      @(negedge clk);
      check("R4 parked outs 4 and 6 low", 32'(prio_irq), 32'hFAF);

      // R5: writes to empty words are dropped
      wr(0, 32'h0101_0101);
      wr(4, 32'h0);
      wr(7, 32'h0);
      wr(15, 32'h0);
      rd("R5 word0 reads zero", 0, 32'h0);
      rd("R5 word4 reads zero", 4, 32'h0);
      rd("R5 word15 reads zero", 15, 32'h0);
      rd("R5 word1 untouched", 1, 32'h4005_7F00);
      rd("R5 word2 untouched", 2, 32'h6480_09C8);
      check("R5 outputs unchanged", 32'(prio_irq), 32'hFAF);

      // R7: read-modify-write of one byte in word 2
      reg_addr = 4'd2; #1; w = reg_rdata;
      @(negedge clk);
      w[15:8] = 8'd7;
      wr(2, w);
      rd("R7 rmw keeps neighbours", 2, 32'h6480_07C8);

      // R8: write-to-output and event-to-output latency
      evt_in = '0; evt_in[50] = 1'b1;
      @(negedge clk); @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = {8'd64, 8'd5, 8'd127, 8'd50};
      @(negedge clk);
      reg_we = 1'b0;
      check("R8 old value after write edge", 32'(prio_irq[0]), 32'h0);
      @(negedge clk);
      check("R8 new select one edge later", 32'(prio_irq[0]), 32'h1);
      evt_in[50] = 1'b0;
      #1;
      check("R8 event not yet seen", 32'(prio_irq[0]), 32'h1);
      @(negedge clk);
      check("R8 event seen one edge later", 32'(prio_irq[0]), 32'h0);

      // R1: random routing and event traffic against the model
      for (int n = 0; n < 3000; n++) begin
         evt_in = {$urandom, $urandom, $urandom, $urandom};
         if (($urandom & 3) == 0) begin
            reg_we = 1'b1; reg_addr = 4'($urandom); reg_wdata = $urandom;
            if ($urandom & 1) reg_wdata = reg_wdata & 32'h7F7F_7F7F;
         end else reg_we = 1'b0;
         @(negedge clk);
      end
      reg_we = 1'b0;
      for (int a = 0; a < 16; a++) rd("R7 final readback", a, model_word(a));

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule